// File: doc/BRIEF.md
# Two-Master Lateral Link Arbiter

This block decides which of two masters in a switch segment may use the single data path that crosses to the neighbouring segment. Each master issues a read or write command that carries a target slave index. Targets inside the segment's own slave window are local: they are accepted at once and never touch the shared path. Targets outside the window are lateral: they compete for the shared path, and one burst at a time owns it.

Ownership starts at command acceptance and ends on the accepted beat that carries the last flag. A stalled receiver, or write data that shows up late, keeps the path claimed, and the other master waits. A new lateral command may be accepted in the same cycle as the owner's final beat, so bursts can follow each other with no gap. When a write burst takes over from a write burst of the other master, the first cycle of the new ownership is a dead cycle in which no beat may move. Read handovers and write bursts repeated by the same master need no dead cycle. When both masters request together, the master that did not own the most recent lateral burst wins. Two instances are used, one for each pair of masters.

Top module: `lat_link_arb`

## Requirements
- R1: A target index in the window [SEG_BASE, SEG_BASE+SEG_SLAVES) is local and any other index is lateral. With the defaults, indices 0 to 3 are local and 4 to 7 are lateral.
- R2: A local command sees `cmd_ready` high in the cycle it is presented, whatever the state of the link. It does not make the link busy, does not change the owner and never causes a dead cycle.
- R3: A lateral command is accepted only when the link is idle, or in the cycle in which the owner's beat with `dat_last` high is accepted. At most one lateral command is accepted per cycle.
- R4: When both masters present lateral commands in a cycle where the link is free, the master that did not own the most recent lateral burst is granted. After reset, master 0 wins.
- R5: From the cycle after acceptance until the owner's last beat is accepted, `link_busy` stays high and `link_owner` stays unchanged. A beat is accepted when `dat_valid`, `dat_ready` and `dat_pass` are all high. Stalls on `dat_ready` and write data that arrives late do not release the link.
- R6: At most one bit of `dat_pass` is high. A bit is high only for the current owner, and only while the link is busy and not in a dead cycle.
- R7: A lateral write that follows a lateral write of the other master has `link_bubble` high and `dat_pass` all zero in its first cycle of ownership. The dead cycle lasts exactly one cycle.
- R8: A lateral read never starts with a dead cycle, and neither does a write whose previous lateral burst was a write by the same master.
- R9: With both masters streaming single-beat lateral writes, one beat moves every two cycles: 6 beats take 12 cycles. With two 8-beat writes from each master, 32 beats take 36 cycles. Each count runs from the first acceptance to the last beat, inclusive.
- R10: While and after reset, the link is idle with no owner: `link_busy`, `link_bubble` and `dat_pass` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 2 | Command valid, one bit per master |
| cmd_write | input | 2 | Command is a write (1) or a read (0), per master |
| cmd_dest | input | 2*SLV_W | Target slave index; master i uses bits [i*SLV_W +: SLV_W] |
| cmd_ready | output | 2 | Command accepted in this cycle when the matching valid bit is high |
| dat_valid | input | 2 | Beat offered on the lateral path, per master |
| dat_ready | input | 2 | Receiver ready for the beat, per master |
| dat_last | input | 2 | Offered beat is the last of its burst |
| dat_pass | output | 2 | Lateral path open to this master in this cycle |
| link_busy | output | 1 | Lateral path is owned by a burst |
| link_owner | output | 1 | Index of the owning master |
| link_bubble | output | 1 | Current cycle is a write turnaround dead cycle |

## Verification
The assertions assume that each master follows the handshake discipline. A master offers beats only for a lateral burst it owns. It raises `dat_last` exactly on the final beat of that burst, and it issues no new command to itself until its previous burst has ended, or ends in the same cycle. The bench builds every master pattern from a small model that keeps these rules: it counts the outstanding beats of each master, raises last only when one beat is left, and offers a follow-on command only in the cycle its final beat is accepted. Stalls, late write data and simultaneous requests are then layered on top of that model.

// File: rtl/latarb_pkg.sv
package latarb_pkg;

   localparam int unsigned LA_MASTERS = 2;

   // registered view of the shared lateral path
   typedef struct packed {
      logic busy;    // a burst holds the path
      logic owner;   // index of the holding master
      logic wr;      // holding burst is a write
      logic bubble;  // turnaround dead cycle in progress
   } link_st_t;

   // history of the most recent lateral burst, used for fairness and turnaround
   typedef struct packed {
      logic vld;
      logic owner;
      logic wr;
   } link_hist_t;

   // two-way round-robin choice: on a tie the favoured side wins
   function automatic logic [1:0] rr_choose(input logic [1:0] req, input logic favour_b);
      logic [1:0] pick;
      if (req == 2'b11) pick = favour_b ? 2'b10 : 2'b01;
      else              pick = req;
      return pick;
   endfunction

endpackage

// File: rtl/lat_decode.sv
module lat_decode #(
   parameter int unsigned SLV_W      = 3,
   parameter int unsigned SEG_BASE   = 0,
   parameter int unsigned SEG_SLAVES = 4
) (
   input  logic [SLV_W-1:0] dest,
   output logic             lateral
);

   localparam int unsigned SEG_END = SEG_BASE + SEG_SLAVES;
   localparam logic [SLV_W:0] LO_V = (SLV_W+1)'(SEG_BASE);
   localparam logic [SLV_W:0] HI_V = (SLV_W+1)'(SEG_END);

   logic [SLV_W:0] dest_x;
   logic           in_seg;

   assign dest_x = {1'b0, dest};
   assign in_seg = (dest_x >= LO_V) && (dest_x < HI_V);
   assign lateral = !in_seg;

endmodule

// File: rtl/lat_arbiter.sv
module lat_arbiter
   import latarb_pkg::*;
(
   input  logic [1:0] lat_req,
   input  logic       free,
   input  logic       favour_b,
   output logic [1:0] grant
);

   always_comb begin
      grant = 2'b00;
      if (free) grant = rr_choose(lat_req, favour_b);
   end

endmodule

// File: rtl/lat_lock.sv
module lat_lock
   import latarb_pkg::*;
#(
   parameter int unsigned TURN_CYC = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] grant,
   input  logic       grant_wr,
   input  logic [1:0] beat_acc,
   input  logic [1:0] beat_last,
   output link_st_t   st,
   output logic       free,
   output logic       favour_b,
   output logic [1:0] pass
);

   link_hist_t hist;
   logic       gnt_any;
   logic       gnt_id;
   logic       last_acc;
   logic       turn;
   logic       bubble_d;

   assign gnt_any  = |grant;
   assign gnt_id   = grant[1];
   assign last_acc = st.busy && beat_acc[st.owner] && beat_last[st.owner];
   assign free     = !st.busy || last_acc;
   assign favour_b = !hist.owner;
   assign turn     = grant_wr && hist.vld && hist.wr && (hist.owner != gnt_id);

   generate
      if (TURN_CYC == 1) begin : g_turn
         assign bubble_d = gnt_any && turn;
      end else begin : g_noturn
         assign bubble_d = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= '0;
         hist <= '{vld: 1'b0, owner: 1'b1, wr: 1'b0};
      end else if (gnt_any) begin
         st   <= '{busy: 1'b1, owner: gnt_id, wr: grant_wr, bubble: bubble_d};
         hist <= '{vld: 1'b1, owner: gnt_id, wr: grant_wr};
      end else begin
         st.bubble <= 1'b0;
         if (last_acc) st.busy <= 1'b0;
      end
   end

   always_comb begin
      pass = 2'b00;
      if (st.busy && !st.bubble) pass[st.owner] = 1'b1;
   end

   // R3
   grant_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_any |-> free);

   // R3
   grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R5
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st.busy && !last_acc) |=> (st.busy && (st.owner == $past(st.owner))));

   // R6
   pass_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pass));

   // R7
   bubble_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st.bubble |-> (pass == 2'b00));

   // R7
   bubble_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st.bubble |=> !st.bubble);

   // R8
   read_no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_any && !grant_wr) |=> !st.bubble);

endmodule

// File: rtl/lat_link_arb.sv
module lat_link_arb
   import latarb_pkg::*;
#(
   parameter int unsigned SLV_W      = 3,
   parameter int unsigned SEG_BASE   = 0,
   parameter int unsigned SEG_SLAVES = 4,
   parameter int unsigned TURN_CYC   = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           cmd_valid,
   input  logic [1:0]           cmd_write,
   input  logic [2*SLV_W-1:0]   cmd_dest,
   output logic [1:0]           cmd_ready,
   input  logic [1:0]           dat_valid,
   input  logic [1:0]           dat_ready,
   input  logic [1:0]           dat_last,
   output logic [1:0]           dat_pass,
   output logic                 link_busy,
   output logic                 link_owner,
   output logic                 link_bubble
);

   localparam int unsigned N_MST   = LA_MASTERS;
   localparam int unsigned N_SLV   = 1 << SLV_W;
   localparam int unsigned SEG_END = SEG_BASE + SEG_SLAVES;

   generate
      if (SLV_W < 1 || SLV_W > 8) begin : g_bad_w
         $error("SLV_W out of range");
      end
      if (SEG_SLAVES < 1 || SEG_END > N_SLV) begin : g_bad_seg
         $error("segment window does not fit the slave index space");
      end
      if (TURN_CYC > 1) begin : g_bad_turn
         $error("TURN_CYC must be 0 or 1");
      end
   endgenerate

   logic [N_MST-1:0] lat;
   logic [N_MST-1:0] lat_req;
   logic [N_MST-1:0] grant;
   logic [N_MST-1:0] beat_acc;
   logic             grant_wr;
   logic             free;
   logic             favour_b;
   link_st_t         st;

   generate
      for (genvar gi = 0; gi < N_MST; gi++) begin : g_mst
         lat_decode #(
            .SLV_W      (SLV_W),
            .SEG_BASE   (SEG_BASE),
            .SEG_SLAVES (SEG_SLAVES)
         ) u_dec (
            .dest    (cmd_dest[gi*SLV_W +: SLV_W]),
            .lateral (lat[gi])
         );
         assign lat_req[gi]   = cmd_valid[gi] && lat[gi];
         assign cmd_ready[gi] = lat[gi] ? grant[gi] : 1'b1;
      end
   endgenerate

   lat_arbiter u_arb (
      .lat_req  (lat_req),
      .free     (free),
      .favour_b (favour_b),
      .grant    (grant)
   );

   assign grant_wr = grant[1] ? cmd_write[1] : cmd_write[0];
   assign beat_acc = dat_valid & dat_ready & dat_pass;

   lat_lock #(
      .TURN_CYC (TURN_CYC)
   ) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant     (grant),
      .grant_wr  (grant_wr),
      .beat_acc  (beat_acc),
      .beat_last (dat_last),
      .st        (st),
      .free      (free),
      .favour_b  (favour_b),
      .pass      (dat_pass)
   );

   assign link_busy   = st.busy;
   assign link_owner  = st.owner;
   assign link_bubble = st.bubble;

   // R2
   local_no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_busy && ((cmd_valid & cmd_ready & lat) == 2'b00)) |=> !link_busy);

   // R3
   busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_busy && ((dat_valid & dat_ready & dat_last & dat_pass) == 2'b00))
         |-> ((cmd_ready & lat) == 2'b00));

   // R10
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!link_busy || $past(rst_n)));

endmodule

// File: tb/test_lat_link_arb.sv
module test_lat_link_arb;

   localparam int SLV_W = 3;

   logic             clk;
   logic             rst_n;
   logic [1:0]       cv, cw, dv, dr, dl;
   logic [2*SLV_W-1:0] cd;
   logic [1:0]       cmd_ready, dat_pass;
   logic             link_busy, link_owner, link_bubble;

   int nchk = 0;
   int nerr = 0;

   lat_link_arb #(.SLV_W(SLV_W)) i_lat_link_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cv),
      .cmd_write   (cw),
      .cmd_dest    (cd),
      .cmd_ready   (cmd_ready),
      .dat_valid   (dv),
      .dat_ready   (dr),
      .dat_last    (dl),
      .dat_pass    (dat_pass),
      .link_busy   (link_busy),
      .link_owner  (link_owner),
      .link_bubble (link_bubble)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle_in();
      cv = '0; cw = '0; dv = '0; dr = '0; dl = '0; cd = '0;
   endtask

   // move to the next negedge and let combinational outputs settle
   task automatic tick();
      @(negedge clk);
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle_in();
      rst_n = 1'b0;
      #1;
      chk("R10", "busy in reset", int'(link_busy), 0);
      chk("R10", "pass in reset", int'(dat_pass), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R10", "busy after reset", int'(link_busy), 0);
      chk("R10", "bubble after reset", int'(link_bubble), 0);
      chk("R10", "pass after reset", int'(dat_pass), 0);
   endtask

   task automatic set_cmd(input int m, input bit wr, input int dest);
      cv[m] = 1'b1;
      cw[m] = wr;
      cd[m*SLV_W +: SLV_W] = SLV_W'(dest);
   endtask

   task automatic t_decode();
      do_reset();
      for (int d = 0; d < 8; d++) begin
         tick(); idle_in(); set_cmd(0, 1'b0, d); settle();
         chk("R1", "ready for idle link", int'(cmd_ready[0]), 1);
         tick(); idle_in(); settle();
         chk("R1", $sformatf("busy after dest %0d", d), int'(link_busy), (d >= 4) ? 1 : 0);
         if (d >= 4) begin
            chk("R6", "pass to owner", int'(dat_pass), 1);
            dv = 2'b01; dr = 2'b01; dl = 2'b01;
            tick(); idle_in(); settle();
            chk("R5", "released after last", int'(link_busy), 0);
         end
      end
   endtask

   task automatic t_local();
      do_reset();
      tick(); idle_in(); set_cmd(1, 1'b0, 5); settle();
      chk("R3", "lateral grant M1", int'(cmd_ready), 3);
      tick(); idle_in(); set_cmd(0, 1'b1, 2); settle();
      chk("R2", "local ready while link held", int'(cmd_ready[0]), 1);
      chk("R2", "owner before local", int'(link_owner), 1);
      tick(); idle_in(); settle();
      chk("R2", "owner unchanged by local", int'(link_owner), 1);
      chk("R2", "no bubble from local", int'(link_bubble), 0);
      chk("R6", "pass stays with M1", int'(dat_pass), 2);
      dv = 2'b10; dr = 2'b10; dl = 2'b10;
      tick(); idle_in(); set_cmd(0, 1'b1, 3); set_cmd(1, 1'b1, 1); settle();
      chk("R2", "both local ready", int'(cmd_ready), 3);
      tick(); idle_in(); settle();
      chk("R2", "local does not claim link", int'(link_busy), 0);
   endtask

   task automatic t_stall_read();
      do_reset();
      tick(); idle_in(); set_cmd(0, 1'b0, 4); settle();
      chk("R3", "M0 granted", int'(cmd_ready[0]), 1);
      tick(); idle_in(); set_cmd(1, 1'b0, 6); dv = 2'b01; dr = 2'b01; settle();
      chk("R3", "M1 blocked", int'(cmd_ready[1]), 0);
      chk("R6", "pass only M0", int'(dat_pass), 1);
      for (int k = 0; k < 3; k++) begin
         tick(); dr = 2'b00; settle();
         chk("R5", "held during stall", int'(link_busy), 1);
         chk("R5", "owner during stall", int'(link_owner), 0);
         chk("R3", "M1 blocked in stall", int'(cmd_ready[1]), 0);
      end
      tick(); dr = 2'b01; settle();
      tick(); settle();
      chk("R3", "M1 blocked before last", int'(cmd_ready[1]), 0);
      tick(); dl = 2'b01; settle();
      chk("R3", "handover with last beat", int'(cmd_ready[1]), 1);
      tick(); idle_in(); dv = 2'b10; dr = 2'b10; dl = 2'b10; settle();
      chk("R8", "read handover no bubble", int'(link_bubble), 0);
      chk("R6", "pass moves to M1", int'(dat_pass), 2);
      tick(); idle_in(); settle();
      chk("R5", "idle after M1 read", int'(link_busy), 0);
   endtask

   task automatic t_late_write();
      do_reset();
      tick(); idle_in(); set_cmd(1, 1'b1, 7); settle();
      chk("R3", "M1 write granted", int'(cmd_ready[1]), 1);
      for (int k = 0; k < 3; k++) begin
         tick(); idle_in(); set_cmd(0, 1'b1, 5); settle();
         chk("R5", "path held with no data", int'(dat_pass), 2);
         chk("R3", "M0 waits", int'(cmd_ready[0]), 0);
      end
      tick(); dv = 2'b10; dr = 2'b10; settle();
      chk("R3", "M0 waits mid burst", int'(cmd_ready[0]), 0);
      tick(); dl = 2'b10; settle();
      chk("R3", "M0 granted at last", int'(cmd_ready[0]), 1);
      tick(); idle_in(); settle();
      chk("R7", "bubble on write handover", int'(link_bubble), 1);
      chk("R7", "no pass in bubble", int'(dat_pass), 0);
      chk("R7", "owner is M0", int'(link_owner), 0);
      tick(); settle();
      chk("R7", "bubble lasts one cycle", int'(link_bubble), 0);
      chk("R7", "pass after bubble", int'(dat_pass), 1);
      dv = 2'b01; dr = 2'b01; dl = 2'b01;
      tick(); idle_in(); settle();
   endtask

   task automatic t_rr();
      do_reset();
      tick(); idle_in(); set_cmd(0, 1'b0, 4); set_cmd(1, 1'b0, 5); settle();
      chk("R4", "tie after reset to M0", int'(cmd_ready), 1);
      tick(); dv = 2'b01; dr = 2'b01; dl = 2'b01; settle();
      chk("R4", "tie goes to M1", int'(cmd_ready), 2);
      tick(); dv = 2'b10; dr = 2'b10; dl = 2'b10; settle();
      chk("R4", "tie goes back to M0", int'(cmd_ready), 1);
      tick(); idle_in(); dv = 2'b01; dr = 2'b01; dl = 2'b01; settle();
      tick(); idle_in(); settle();
      chk("R4", "idle after rotation", int'(link_busy), 0);
   endtask

   task automatic t_same_write();
      do_reset();
      tick(); idle_in(); set_cmd(0, 1'b1, 6); settle();
      tick(); idle_in(); set_cmd(0, 1'b1, 6); dv = 2'b01; dr = 2'b01; dl = 2'b01; settle();
      chk("R3", "same master back to back", int'(cmd_ready[0]), 1);
      tick(); idle_in(); settle();
      chk("R8", "no bubble same master", int'(link_bubble), 0);
      chk("R8", "pass same master", int'(dat_pass), 1);
      dv = 2'b01; dr = 2'b01; dl = 2'b01;
      tick(); idle_in(); settle();
   endtask

   // both masters stream lateral writes; count cycles and dead cycles
   task automatic t_thru(input int nbeat, input int nburst, input int exp_cyc);
      int left [2];
      int outst [2];
      int cyc, start, last_cyc, beats, bubbles;
      bit started;
      do_reset();
      left[0] = nburst; left[1] = nburst; outst[0] = 0; outst[1] = 0;
      cyc = 0; start = 0; last_cyc = 0; beats = 0; bubbles = 0; started = 0;
      while ((beats < 2*nbeat*nburst) && (cyc < 400)) begin
         tick(); idle_in();
         for (int m = 0; m < 2; m++) begin
            bit finishing;
            finishing = (outst[m] == 1) && dat_pass[m];
            if ((left[m] > 0) && ((outst[m] == 0) || finishing)) set_cmd(m, 1'b1, 4 + m);
            dv[m] = (outst[m] > 0);
            dr[m] = 1'b1;
            dl[m] = (outst[m] == 1);
         end
         settle();
         if (link_bubble) bubbles++;
         for (int m = 0; m < 2; m++) begin
            if (dv[m] && dat_pass[m]) begin
               outst[m]--; beats++; last_cyc = cyc;
            end
            if (cv[m] && cmd_ready[m]) begin
               outst[m] = nbeat; left[m]--;
               if (!started) begin started = 1; start = cyc; end
            end
         end
         cyc++;
      end
      tick(); idle_in(); settle();
      chk("R9", $sformatf("beats moved, %0d-beat bursts", nbeat), beats, 2*nbeat*nburst);
      chk("R9", $sformatf("cycles, %0d-beat bursts", nbeat), last_cyc - start + 1, exp_cyc);
      chk("R7", $sformatf("dead cycles, %0d-beat bursts", nbeat), bubbles, 2*nburst - 1);
      chk("R10", "idle at end", int'(link_busy), 0);
   endtask

   initial begin
      #2_000_000;
      nerr++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      idle_in();
      t_decode();
      t_local();
      t_stall_read();
      t_late_write();
      t_rr();
      t_same_write();
      t_thru(1, 3, 12);
      t_thru(8, 2, 36);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule